// File: doc/BRIEF.md
# Diagonal-Sum Column Multiplier

This block multiplies two unsigned N-bit operands and returns their 2N-bit product. It does not add shifted rows of partial products. It forms every single-bit product a[i]&b[j] at the same time. It then builds the result one column at a time. For each column k it counts the bit products whose indices satisfy i+j=k and adds the carry from column k-1. The least significant bit of that total becomes product bit k. The remaining upper bits travel on as the carry into column k+1. Column 0 starts with a zero carry. The carry between columns is wide enough that a column holding N products plus the largest possible incoming carry never overflows. The top columns have no products left, so the last carries drain into the upper product bits.

Operands enter through a valid/ready stream port and the product leaves through a second one. With the output register enabled (REG_OUT=1, the default), a pair of operands is taken on any cycle where in_valid and in_ready are both high. Its product appears with out_valid one cycle later. That product stays unchanged while out_ready is low, and in_ready drops for as long as it is held. When out_ready is high, the held result leaves and a new pair can be taken on the same edge. With REG_OUT=0 the block is purely combinational. The handshake signals then pass straight across.

Top module: `vcm_mult`

## Requirements
- R1: For every pair of unsigned operands, product equals a*b, using all 2N bits.
- R2: When both operands are all ones, product equals (2^N-1)^2; the carry leaving the last column is always zero.
- R3: When either operand is zero, product is zero.
- R4: While rst_n is low, and after reset until the first pair is taken, out_valid is 0 and in_ready is 1 (REG_OUT=1).
- R5: A pair taken on an edge with in_valid=1 and in_ready=1 gives out_valid=1 after that edge, with product equal to that pair's product (REG_OUT=1).
- R6: While out_valid=1 and out_ready=0, out_valid stays 1, product does not change, and in_ready is 0, whatever the operand inputs do (REG_OUT=1).
- R7: out_ready=1 forces in_ready=1. A pair offered in the cycle the held result is taken replaces it, and with no pair offered out_valid falls (REG_OUT=1).
- R8: With REG_OUT=0, out_valid follows in_valid, in_ready follows out_ready, and product follows the operands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block can take an operand pair |
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier |
| out_valid | output | 1 | product holds a result |
| out_ready | input | 1 | Downstream takes the result |
| product | output | 2N | Unsigned product a*b |

## Verification
Two events can fall on the same edge: the downstream taking the held result and a new operand pair being captured. The bench provokes this by first stalling a result with out_ready low while new operands wait on the input. It then raises out_ready with in_valid still high. It judges the case by requiring in_ready to go high in that same cycle and by requiring the new product to replace the old one after the edge with no idle cycle between them. Product values come from the integer product computed in the bench. They are checked over every operand pair at N=4 and over corner and random pairs at N=8.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  // carry between columns: a column sums at most N products plus a carry that
  // never exceeds N, so clog2(N+1) bits hold it; one spare bit as margin
  function automatic int carry_width(input int n);
    return $clog2(n + 1) + 1;
  endfunction
endpackage

// File: rtl/vcm_bitgrid.sv
module vcm_bitgrid #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [N*N-1:0] pp
);
  // every single-bit product, all formed in parallel; pp[i*N+j] = a[i] & b[j]
  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      assign pp[i*N+j] = a[i] & b[j];
    end
  end
endmodule

// File: rtl/vcm_column.sv
module vcm_column #(
  parameter int N  = 8,
  parameter int CW = 5
) (
  input  logic [N-1:0]  diag,
  input  logic [CW-1:0] cin,
  output logic          bit_o,
  output logic [CW-1:0] cout
);
  localparam int SW = CW + 1;

  logic [SW-1:0] sum;

  always_comb begin
    sum = SW'(cin);
    for (int k = 0; k < N; k++) begin
      sum = sum + SW'(diag[k]);
    end
  end

  assign bit_o = sum[0];
  assign cout  = sum[SW-1:1];
endmodule

// File: rtl/vcm_out_stage.sv
module vcm_out_stage #(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  if (REG_OUT) begin : g_reg
    logic         valid_q;
    logic [W-1:0] data_q;
    logic         load;

    assign in_ready = !valid_q || out_ready;
    assign load     = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        data_q  <= '0;
      end else begin
        if (load) begin
          data_q <= d;
        end
        if (load) begin
          valid_q <= 1'b1;
        end else if (out_ready) begin
          valid_q <= 1'b0;
        end
      end
    end

    assign out_valid = valid_q;
    assign q         = data_q;
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst_n;
    assign in_ready       = out_ready;
    assign out_valid      = in_valid;
    assign q              = d;
  end
endmodule

// File: rtl/vcm_mult.sv
module vcm_mult #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*N-1:0] product
);
  localparam int PW   = 2 * N;
  localparam int NCOL = 2 * N;
  localparam int CW   = vcm_pkg::carry_width(N);

  logic [N*N-1:0]           pp;
  logic [NCOL:0][CW-1:0]    carry;
  logic [PW-1:0]            raw;

  vcm_bitgrid #(.N(N)) u_grid (
    .a  (a),
    .b  (b),
    .pp (pp)
  );

  assign carry[0] = '0;

  for (genvar k = 0; k < NCOL; k++) begin : g_colk
    logic [N-1:0] diag;
    for (genvar i = 0; i < N; i++) begin : g_pick
      if ((k >= i) && (k - i < N)) begin : g_on
        assign diag[i] = pp[i*N + (k - i)];
      end else begin : g_off
        assign diag[i] = 1'b0;
      end
    end
    vcm_column #(.N(N), .CW(CW)) u_col (
      .diag  (diag),
      .cin   (carry[k]),
      .bit_o (raw[k]),
      .cout  (carry[k+1])
    );
  end

  vcm_out_stage #(.W(PW), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         (raw),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (product)
  );
endmodule

// File: rtl/vcm_mult_chk.sv
module vcm_mult_chk #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1,
  parameter int CW      = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [N-1:0]   a,
  input logic [N-1:0]   b,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*N-1:0] product,
  input logic [CW-1:0]  final_carry
);
  localparam int PW = 2 * N;

  assert_final_carry_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    final_carry == '0);

  if (REG_OUT) begin : g_reg
    assert_reset_idle_R4: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && in_ready));

    assert_accept_product_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=>
        (out_valid && product == PW'($past(a)) * PW'($past(b))));

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(product)));

    assert_stall_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

    assert_ready_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |-> in_ready);
  end else begin : g_comb
    assert_comb_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
      product == PW'(a) * PW'(b));

    assert_zero_operand_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (a == '0 || b == '0) |-> product == '0);

    assert_comb_handshake_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == in_valid) && (in_ready == out_ready));
  end
endmodule

bind vcm_mult vcm_mult_chk #(
  .N(N), .REG_OUT(REG_OUT), .CW(vcm_pkg::carry_width(N))
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .a           (a),
  .b           (b),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .product     (product),
  .final_carry (carry[2*N])
);

// File: tb/tb_vcm_mult.sv
module tb_vcm_mult;
  localparam int NS = 4;
  localparam int NB = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;

  // registered instance, small width, swept exhaustively
  logic            in_valid, in_ready, out_valid, out_ready;
  logic [NS-1:0]   a, b;
  logic [2*NS-1:0] product;

  // combinational instance, default width
  logic            c_in_valid, c_in_ready, c_out_valid, c_out_ready;
  logic [NB-1:0]   ca, cb;
  logic [2*NB-1:0] c_product;

  vcm_mult #(.N(NS), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a(a), .b(b), .out_valid(out_valid), .out_ready(out_ready), .product(product)
  );

  vcm_mult #(.N(NB), .REG_OUT(1'b0)) dut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(c_in_valid), .in_ready(c_in_ready),
    .a(ca), .b(cb), .out_valid(c_out_valid), .out_ready(c_out_ready),
    .product(c_product)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic comb_case(input int x, input int y, input string tag);
    ca          = NB'(x);
    cb          = NB'(y);
    c_in_valid  = x[0];
    c_out_ready = y[1];
    #2;
    chk(tag, c_product, longint'(x) * longint'(y));
    chk("R8 out_valid", c_out_valid, x[0]);
    chk("R8 in_ready", c_in_ready, y[1]);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int exp_prev;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; a = '0; b = '0;
    c_in_valid = 1'b0; c_out_ready = 1'b0; ca = '0; cb = '0;
    repeat (3) @(negedge clk);
    chk("R4 out_valid in reset", out_valid, 0);
    chk("R4 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 out_valid idle", out_valid, 0);
    chk("R4 in_ready idle", in_ready, 1);

    // every operand pair at N=4, streamed back to back
    for (int v = 0; v < 256; v++) begin
      a = NS'(v);
      b = NS'(v >> 4);
      in_valid = 1'b1;
      exp_prev = (v & 15) * (v >> 4);
      @(negedge clk);
      chk("R5 out_valid", out_valid, 1);
      if ((v & 15) == 15 && (v >> 4) == 15)
        chk("R2 all ones N=4", product, 225);
      else if ((v & 15) == 0 || (v >> 4) == 0)
        chk("R3 zero operand N=4", product, 0);
      else
        chk("R1 product N=4", product, exp_prev);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 drains with no new pair", out_valid, 0);

    // stall, then take the result and a new pair on the same edge
    out_ready = 1'b0;
    a = 4'd13; b = 4'd11; in_valid = 1'b1;
    @(negedge clk);
    chk("R5 stalled capture", product, 143);
    chk("R6 in_ready low", in_ready, 0);
    a = 4'd2; b = 4'd3;
    @(negedge clk);
    chk("R6 product held", product, 143);
    chk("R6 out_valid held", out_valid, 1);
    out_ready = 1'b1;
    #1;
    chk("R7 in_ready follows out_ready", in_ready, 1);
    @(negedge clk);
    chk("R7 replaced same edge", product, 6);
    chk("R7 out_valid kept", out_valid, 1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 out_valid falls", out_valid, 0);

    // N=8 combinational: every a against corner values of b
    for (int x = 0; x < 256; x++) begin
      comb_case(x, 0, "R3 zero operand N=8");
      comb_case(x, 1, "R1 times one N=8");
      comb_case(x, 255, "R1 times all ones N=8");
      comb_case(x, 128, "R1 times top bit N=8");
    end
    comb_case(255, 255, "R2 all ones N=8");
    comb_case(0, 255, "R3 zero operand N=8");
    for (int r = 0; r < 1500; r++) begin
      comb_case(int'($urandom_range(255)), int'($urandom_range(255)),
                "R1 random N=8");
    end

    summary();
    $finish;
  end
endmodule